// File: doc/BRIEF.md
# Clock-Stop Handshake and Access Isolation

This block sits between a bus interconnect port and a GPIO peripheral whose functional clock can be moved from the main synchronous clock to an on-chip low-power clock. It answers a power controller's clock-stop request, drives the select line of the functional clock mux from a configuration bit, and isolates the peripheral's register port while the peripheral may be running on a clock that is not synchronous to the bus. The bus path has no clock-domain crossing, so register accesses may only reach the peripheral while the main clock is selected.

Two stop modes exist. When wakeup is enabled at the moment a request is accepted, the request is looped back as an acknowledge one cycle later and never reaches the peripheral, so the peripheral keeps watching its pins on the alternate clock. When wakeup is disabled, the request is forwarded and the acknowledge waits for the peripheral's own acknowledge. In both modes, from acceptance until release, every bus access is completed by a null responder in the same cycle: reads return zero, writes are dropped. Release needs the request to be withdrawn, the select driven back to the main clock and the mux status to report the main clock.

Top module: `clk_stop_iso`

## Requirements
- R1: In the run state every bus access is passed to the peripheral port unchanged, and the peripheral's ready and read data are returned to the bus in the same cycle.
- R2: With wakeup disabled at acceptance, the peripheral stop request rises one cycle after acceptance, and the stop acknowledge rises one cycle after the peripheral acknowledge is seen high.
- R3: With wakeup enabled at acceptance, the stop acknowledge rises one cycle after acceptance and the peripheral stop request stays low throughout.
- R4: From the cycle after acceptance until the cycle after release, the peripheral valid stays low whatever the bus drives.
- R5: While isolated, any bus access is answered with ready high in the same cycle and read data of zero.
- R6: The stop acknowledge only falls, one cycle later, after a cycle in which the request is low, the select output is 0 (main clock) and the mux status input is 1 (main clock selected).
- R7: In forwarded mode, release drops both the acknowledge and the peripheral stop request; bus access returns to the peripheral one cycle after the peripheral acknowledge is seen low.
- R8: The mux select output equals the configuration bit delayed by one cycle; 1 selects the on-chip clock, 0 the main clock.
- R9: The wakeup enable is sampled only when a request is accepted; changing it afterwards has no effect on that stop.
- R10: A request is not accepted in a cycle where a bus access to the peripheral is pending without ready; it is accepted in the cycle the access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main synchronous clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wake_en_i | input | 1 | Wakeup enable configuration bit |
| sel_alt_cfg_i | input | 1 | Mux select configuration bit, 1 = on-chip clock |
| mux_main_i | input | 1 | Mux status, 1 = main clock selected |
| clk_sel_o | output | 1 | Mux select to the clock mux |
| stop_req_i | input | 1 | Clock-stop request from power controller |
| stop_ack_o | output | 1 | Clock-stop acknowledge to power controller |
| periph_stop_req_o | output | 1 | Clock-stop request to peripheral |
| periph_stop_ack_i | input | 1 | Clock-stop acknowledge from peripheral |
| bus_valid_i | input | 1 | Bus access valid |
| bus_write_i | input | 1 | Bus access is a write |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_wdata_i | input | DATA_W | Bus write data |
| bus_ready_o | output | 1 | Bus access complete |
| bus_rdata_o | output | DATA_W | Bus read data |
| per_valid_o | output | 1 | Peripheral access valid |
| per_write_o | output | 1 | Peripheral access is a write |
| per_addr_o | output | ADDR_W | Peripheral address |
| per_wdata_o | output | DATA_W | Peripheral write data |
| per_ready_i | input | 1 | Peripheral access complete |
| per_rdata_i | input | DATA_W | Peripheral read data |

## Verification
A clock-stop request and a bus access to the peripheral can fall in the same cycle. The bench raises the request while a peripheral access is held without ready, checks that the access stays forwarded and no stop is accepted, then gives ready in that same cycle and checks that the access completes from the peripheral and that isolation and the acknowledge start one cycle later.

// File: rtl/clk_stop_iso_pkg.sv
package clk_stop_iso_pkg;
  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_FWD = 2'd1,
    ST_ISO = 2'd2,
    ST_REL = 2'd3
  } csi_state_e;
endpackage

// File: rtl/csi_fsm.sv
module csi_fsm
  import clk_stop_iso_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_req_i,
  input  logic wake_en_i,
  input  logic periph_ack_i,
  input  logic mux_main_i,
  input  logic clk_sel_i,
  input  logic busy_i,
  output logic stop_ack_o,
  output logic periph_req_o,
  output logic isolate_o
);
  csi_state_e state_q, state_d;
  logic       loop_q, loop_d;

  always_comb begin
    state_d = state_q;
    loop_d  = loop_q;
    unique case (state_q)
      ST_RUN: if (stop_req_i && !busy_i) begin
        loop_d  = wake_en_i;
        state_d = wake_en_i ? ST_ISO : ST_FWD;
      end
      ST_FWD: if (periph_ack_i) state_d = ST_ISO;
      ST_ISO: if (!stop_req_i && mux_main_i && !clk_sel_i)
        state_d = loop_q ? ST_RUN : ST_REL;
      ST_REL: if (!periph_ack_i) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      loop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      loop_q  <= loop_d;
    end
  end

  assign stop_ack_o   = (state_q == ST_ISO);
  assign periph_req_o = (state_q == ST_FWD) || ((state_q == ST_ISO) && !loop_q);
  assign isolate_o    = (state_q != ST_RUN);
endmodule

// File: rtl/csi_clk_sel.sv
module csi_clk_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_i,
  output logic sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_o <= 1'b0;
    else         sel_o <= cfg_i;
  end
endmodule

// File: rtl/csi_null_rsp.sv
module csi_null_rsp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              valid_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o
);
  assign ready_o = valid_i;
  assign rdata_o = '0;
endmodule

// File: rtl/csi_route.sv
module csi_route #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              isolate_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_ready_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              per_valid_o,
  output logic              per_write_o,
  output logic [ADDR_W-1:0] per_addr_o,
  output logic [DATA_W-1:0] per_wdata_o,
  input  logic              per_ready_i,
  input  logic [DATA_W-1:0] per_rdata_i
);
  logic              nul_ready;
  logic [DATA_W-1:0] nul_rdata;

  csi_null_rsp #(.DATA_W(DATA_W)) u_null (
    .valid_i (bus_valid_i && isolate_i),
    .ready_o (nul_ready),
    .rdata_o (nul_rdata)
  );

  assign per_valid_o = bus_valid_i && !isolate_i;
  assign per_write_o = bus_write_i;
  assign per_addr_o  = bus_addr_i;
  assign per_wdata_o = isolate_i ? '0 : bus_wdata_i;
  assign bus_ready_o = isolate_i ? nul_ready : per_ready_i;
  assign bus_rdata_o = isolate_i ? nul_rdata : per_rdata_i;
endmodule

// File: rtl/clk_stop_iso.sv
module clk_stop_iso #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wake_en_i,
  input  logic              sel_alt_cfg_i,
  input  logic              mux_main_i,
  output logic              clk_sel_o,
  input  logic              stop_req_i,
  output logic              stop_ack_o,
  output logic              periph_stop_req_o,
  input  logic              periph_stop_ack_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_ready_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              per_valid_o,
  output logic              per_write_o,
  output logic [ADDR_W-1:0] per_addr_o,
  output logic [DATA_W-1:0] per_wdata_o,
  input  logic              per_ready_i,
  input  logic [DATA_W-1:0] per_rdata_i
);
  logic isolate;
  logic busy;

  // a forwarded access waiting for ready blocks acceptance
  assign busy = per_valid_o && !per_ready_i;

  csi_clk_sel u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (sel_alt_cfg_i),
    .sel_o  (clk_sel_o)
  );

  csi_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stop_req_i   (stop_req_i),
    .wake_en_i    (wake_en_i),
    .periph_ack_i (periph_stop_ack_i),
    .mux_main_i   (mux_main_i),
    .clk_sel_i    (clk_sel_o),
    .busy_i       (busy),
    .stop_ack_o   (stop_ack_o),
    .periph_req_o (periph_stop_req_o),
    .isolate_o    (isolate)
  );

  csi_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .isolate_i   (isolate),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_ready_o (bus_ready_o),
    .bus_rdata_o (bus_rdata_o),
    .per_valid_o (per_valid_o),
    .per_write_o (per_write_o),
    .per_addr_o  (per_addr_o),
    .per_wdata_o (per_wdata_o),
    .per_ready_i (per_ready_i),
    .per_rdata_i (per_rdata_i)
  );
endmodule

// File: rtl/clk_stop_iso_chk.sv
module clk_stop_iso_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mux_main_i,
  input logic              clk_sel_o,
  input logic              sel_alt_cfg_i,
  input logic              stop_req_i,
  input logic              stop_ack_o,
  input logic              periph_stop_req_o,
  input logic              periph_stop_ack_i,
  input logic              bus_valid_i,
  input logic              bus_ready_o,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              per_valid_o
);
  p_iso_no_fwd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ack_o |-> !per_valid_o);

  p_null_rsp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_ack_o && bus_valid_i) |-> (bus_ready_o && bus_rdata_o == '0));

  p_fwd_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stop_ack_o) && periph_stop_req_o) |-> $past(periph_stop_ack_i));

  p_exit_main_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stop_ack_o) |-> ($past(mux_main_i) && !$past(clk_sel_o) && !$past(stop_req_i)));

  p_sel_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_sel_o) |-> (clk_sel_o == $past(sel_alt_cfg_i)));
endmodule

bind clk_stop_iso clk_stop_iso_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .mux_main_i        (mux_main_i),
  .clk_sel_o         (clk_sel_o),
  .sel_alt_cfg_i     (sel_alt_cfg_i),
  .stop_req_i        (stop_req_i),
  .stop_ack_o        (stop_ack_o),
  .periph_stop_req_o (periph_stop_req_o),
  .periph_stop_ack_i (periph_stop_ack_i),
  .bus_valid_i       (bus_valid_i),
  .bus_ready_o       (bus_ready_o),
  .bus_rdata_o       (bus_rdata_o),
  .per_valid_o       (per_valid_o)
);

// File: tb/clk_stop_iso_tb.sv
module clk_stop_iso_tb;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wake_en = 0, sel_cfg = 0, mux_main = 1, clk_sel;
  logic stop_req = 0, stop_ack, p_req, p_ack = 0;
  logic b_valid = 0, b_write = 0, b_ready;
  logic [AW-1:0] b_addr = '0;
  logic [DW-1:0] b_wdata = '0, b_rdata;
  logic p_valid, p_write, p_ready = 0;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_wdata, p_rdata = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clk_stop_iso #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wake_en_i(wake_en), .sel_alt_cfg_i(sel_cfg),
    .mux_main_i(mux_main), .clk_sel_o(clk_sel), .stop_req_i(stop_req),
    .stop_ack_o(stop_ack), .periph_stop_req_o(p_req), .periph_stop_ack_i(p_ack),
    .bus_valid_i(b_valid), .bus_write_i(b_write), .bus_addr_i(b_addr),
    .bus_wdata_i(b_wdata), .bus_ready_o(b_ready), .bus_rdata_o(b_rdata),
    .per_valid_o(p_valid), .per_write_o(p_write), .per_addr_o(p_addr),
    .per_wdata_o(p_wdata), .per_ready_i(p_ready), .per_rdata_i(p_rdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R2 reset ack", stop_ack, 0);
    chk("R3 reset preq", p_req, 0);
    chk("R8 reset sel", clk_sel, 0);
  endtask

  task automatic t_pass();
    b_valid = 1; b_write = 0; b_addr = 12'h04c; p_ready = 1; p_rdata = 32'hA5A5_0001;
    #1;
    chk("R1 fwd valid", p_valid, 1);
    chk("R1 fwd addr", p_addr, 12'h04c);
    chk("R1 rdata", b_rdata, 32'hA5A5_0001);
    chk("R1 ready", b_ready, 1);
    b_write = 1; b_wdata = 32'h1234_5678; p_ready = 0;
    #1;
    chk("R1 wdata", p_wdata, 32'h1234_5678);
    chk("R1 stall ready", b_ready, 0);
    b_valid = 0; b_write = 0;
    step();
  endtask

  task automatic t_loop();
    wake_en = 1; stop_req = 1;
    step();
    chk("R3 ack one cycle", stop_ack, 1);
    chk("R3 preq low", p_req, 0);
    wake_en = 0; // R9: ignored for this stop
    b_valid = 1; b_write = 0; p_ready = 0; p_rdata = 32'hDEAD_BEEF;
    #1;
    chk("R5 null ready", b_ready, 1);
    chk("R5 null rdata", b_rdata, 0);
    chk("R4 no fwd", p_valid, 0);
    b_write = 1;
    #1 chk("R4 write no fwd", p_valid, 0);
    b_valid = 0; b_write = 0;
    sel_cfg = 1; mux_main = 0;
    step();
    chk("R8 sel alt", clk_sel, 1);
    chk("R9 preq still low", p_req, 0);
    stop_req = 0;
    step();
    chk("R6 hold while alt", stop_ack, 1);
    sel_cfg = 0;
    step();
    chk("R8 sel main", clk_sel, 0);
    chk("R6 hold mux not main", stop_ack, 1);
    mux_main = 1;
    step();
    chk("R6 release", stop_ack, 0);
    b_valid = 1; p_ready = 1; p_rdata = 32'h0000_0077;
    #1;
    chk("R1 resume fwd", p_valid, 1);
    chk("R1 resume rdata", b_rdata, 32'h77);
    b_valid = 0;
    step();
  endtask

  task automatic t_forward();
    wake_en = 0; stop_req = 1;
    step();
    chk("R2 preq", p_req, 1);
    chk("R2 ack waits", stop_ack, 0);
    b_valid = 1; p_ready = 1;
    #1 chk("R4 no fwd pending", p_valid, 0);
    b_valid = 0;
    wake_en = 1; // R9: ignored
    step();
    chk("R2 ack still low", stop_ack, 0);
    p_ack = 1;
    step();
    chk("R2 ack after periph", stop_ack, 1);
    chk("R9 preq held", p_req, 1);
    stop_req = 0;
    step();
    chk("R7 ack drop", stop_ack, 0);
    chk("R7 preq drop", p_req, 0);
    b_valid = 1;
    #1 chk("R7 still isolated", p_valid, 0);
    b_valid = 0;
    p_ack = 0;
    step();
    b_valid = 1;
    #1 chk("R7 resume", p_valid, 1);
    b_valid = 0;
    wake_en = 0;
    step();
  endtask

  task automatic t_collide();
    b_valid = 1; p_ready = 0; wake_en = 1; stop_req = 1;
    step();
    chk("R10 not accepted", stop_ack, 0);
    chk("R10 access kept", p_valid, 1);
    p_ready = 1; p_rdata = 32'h55;
    #1 chk("R10 completes from periph", b_rdata, 32'h55);
    step();
    b_valid = 0;
    #1;
    chk("R10 accepted after", stop_ack, 1);
    stop_req = 0;
    step();
    chk("R6 leave", stop_ack, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_loop();
    t_forward();
    t_collide();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule